// File: doc/BRIEF.md
# Outstanding Bus Request Tracker

This block sits in each cache controller attached to a split-transaction snooping bus. Every controller holds an identical copy. A request that appears on the bus is written at the slot given by its bus tag. Its response may come back later, in any order, and it releases that slot again. Because the address comparison runs against all occupied slots at once, the table serves as an associative store, even though writes are indexed by tag. The bus side uses this comparison to refuse a second request to a block that already has an outstanding request. The processor side uses it to decide what a new miss should do.

A processor miss is classified in the same cycle. With no match, it is told to issue, together with the lowest free tag. A read that finds a pending plain read to the same block is told to grab the coming data. Any other match, a match whose slot is being released in that very cycle, or a full table tells the processor to wait and retry. When a response arrives, the table reports four things about that slot: whether this controller takes the data, whether it must drive the shared line, whether its snoop state was recorded, and what that state is.

Each slot runs a three-state machine:
- `SL_FREE` goes to `SL_PEND` on allocation.
- `SL_PEND` goes to `SL_KNOWN` when a snoop result is recorded, back to `SL_FREE` on its response, and is reloaded (stays `SL_PEND`) on allocation.
- `SL_KNOWN` goes to `SL_FREE` on its response, or back to `SL_PEND` on allocation.

The processor decision is one of four actions: `ACT_IDLE`=0, `ACT_ISSUE`=1, `ACT_GRAB`=2, `ACT_WAIT`=3.

Top module: `split_req_table`

## Requirements
- R1: After reset every slot is free, `table_full` is 0, and a processor lookup returns `ACT_ISSUE` with tag 0.
- R2: A bus request (kinds: 0 read, 1 read-exclusive, 2 upgrade) whose block matches no occupied slot is not NACKed, and from the next cycle on it occupies the slot named by its tag.
- R3: A bus request whose block matches an occupied slot raises `req_nack` in the same cycle and leaves the table unchanged.
- R4: On a response, `rsp_take` is 1 only if this controller issued that request or chose to grab it; a request by another controller that was not grabbed gives `rsp_take`=0.
- R5: A processor read that matches a pending read (kind 0) returns `ACT_GRAB`, and the later response for that slot gives `rsp_take`=1.
- R6: A processor read that matches a pending read-exclusive or upgrade, or a processor write that matches any pending request, returns `ACT_WAIT`.
- R7: A response releases its slot. From the next cycle the block no longer matches, and the tag is available for issue again.
- R8: With no match, a lookup returns `ACT_ISSUE` and the lowest free tag. With all slots occupied, it returns `ACT_WAIT` and `table_full` is 1.
- R9: A snoop result written to an occupied slot is reported on that slot's response as `rsp_known`=1 with `rsp_state` equal to the written value.
- R10: A processor lookup that matches a slot being released in the same cycle returns `ACT_WAIT`.
- R11: `rsp_shared` is 1 only for a grabber that did not issue the request. The issuing controller never drives it, even if it also grabbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req_valid | input | 1 | A request phase is on the bus this cycle |
| bus_req_tag | input | TAG_W | Tag assigned to the bus request |
| bus_req_blk | input | BLK_W | Block address of the bus request |
| bus_req_kind | input | 2 | 0 read, 1 read-exclusive, 2 upgrade |
| bus_req_mine | input | 1 | This controller issued the bus request |
| req_nack | output | 1 | Bus request conflicts with an outstanding block |
| bus_rsp_valid | input | 1 | A response phase is on the bus this cycle |
| bus_rsp_tag | input | TAG_W | Tag of the response |
| rsp_take | output | 1 | This controller loads the response data |
| rsp_shared | output | 1 | This controller drives the shared line |
| rsp_known | output | 1 | A snoop state was recorded for the slot |
| rsp_state | output | 2 | Recorded snoop state of the slot |
| snp_valid | input | 1 | Record a snoop result this cycle |
| snp_tag | input | TAG_W | Slot the snoop result belongs to |
| snp_state | input | 2 | Snoop result value |
| cpu_valid | input | 1 | Processor-side lookup this cycle |
| cpu_blk | input | BLK_W | Block address of the processor miss |
| cpu_write | input | 1 | Miss is a write (0 = read) |
| cpu_act | output | 2 | Action for the miss (idle/issue/grab/wait) |
| cpu_tag | output | TAG_W | Lowest free tag, valid with issue |
| table_full | output | 1 | Every slot is occupied |

## Verification
The NACK decision, the processor action, the free tag and all response indications are combinational on the current table contents, so they are due in the same cycle as the stimulus. A table update made by a request, a grab, a snoop or a response only shows from the next cycle on. The driver applies each stimulus just after a rising edge and queues its expectation for that cycle. The monitor compares at the following falling edge, before the update lands. Effects of an update are checked by a separate lookup or response in a later cycle, for example refused requests not taking a slot and released slots being issued again.

// File: rtl/ort_pkg.sv
package ort_pkg;
    typedef enum logic [1:0] {
        RQ_READ  = 2'd0,
        RQ_READX = 2'd1,
        RQ_UPGR  = 2'd2
    } req_kind_t;

    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_ISSUE = 2'd1,
        ACT_GRAB  = 2'd2,
        ACT_WAIT  = 2'd3
    } act_t;

    typedef enum logic [1:0] {
        SL_FREE  = 2'd0,
        SL_PEND  = 2'd1,
        SL_KNOWN = 2'd2
    } slot_st_t;
endpackage

// File: rtl/ort_slot.sv
module ort_slot
    import ort_pkg::*;
#(
    parameter int BLK_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic [BLK_W-1:0] alloc_blk,
    input  logic [1:0]       alloc_kind,
    input  logic             alloc_mine,
    input  logic             release_i,
    input  logic             grab_i,
    input  logic             snp_i,
    input  logic [1:0]       snp_st,
    input  logic [BLK_W-1:0] bus_blk,
    input  logic [BLK_W-1:0] cpu_blk,
    output logic             occ,
    output logic             hit_bus,
    output logic             hit_cpu,
    output logic [1:0]       kind_o,
    output logic             orig_o,
    output logic             grab_o,
    output logic             known_o,
    output logic [1:0]       cst_o
);
    slot_st_t         st_q, st_d;
    logic [BLK_W-1:0] blk_q;
    logic [1:0]       kind_q;
    logic             orig_q, grab_q;
    logic [1:0]       cst_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SL_FREE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SL_FREE:  if (alloc) st_d = SL_PEND;
            SL_PEND: begin
                if (alloc)          st_d = SL_PEND;
                else if (release_i) st_d = SL_FREE;
                else if (snp_i)     st_d = SL_KNOWN;
            end
            SL_KNOWN: begin
                if (alloc)          st_d = SL_PEND;
                else if (release_i) st_d = SL_FREE;
            end
            default: st_d = SL_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q  <= '0;
            kind_q <= '0;
            orig_q <= 1'b0;
            grab_q <= 1'b0;
            cst_q  <= '0;
        end else if (alloc) begin
            blk_q  <= alloc_blk;
            kind_q <= alloc_kind;
            orig_q <= alloc_mine;
            grab_q <= 1'b0;
            cst_q  <= '0;
        end else begin
            if (grab_i) grab_q <= 1'b1;
            if (snp_i && st_q != SL_FREE) cst_q <= snp_st;
        end
    end

    always_comb begin
        occ     = (st_q != SL_FREE);
        hit_bus = occ && (blk_q == bus_blk);
        hit_cpu = occ && (blk_q == cpu_blk);
        kind_o  = kind_q;
        orig_o  = orig_q;
        grab_o  = grab_q;
        known_o = (st_q == SL_KNOWN);
        cst_o   = cst_q;
    end

    AST_RSP_FREES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (release_i && !alloc) |=> (st_q == SL_FREE)); // R7
    AST_ALLOC_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |=> (st_q == SL_PEND && !grab_q)); // R2
endmodule

// File: rtl/ort_pick.sv
module ort_pick #(
    parameter int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] occ_v,
    output logic [TAG_W-1:0] free_idx,
    output logic             any_free
);
    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!occ_v[i]) free_idx = TAG_W'(i);
        end
        any_free = ~&occ_v;
    end
endmodule

// File: rtl/split_req_table.sv
module split_req_table
    import ort_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int BLK_W = 26,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req_valid,
    input  logic [TAG_W-1:0] bus_req_tag,
    input  logic [BLK_W-1:0] bus_req_blk,
    input  logic [1:0]       bus_req_kind,
    input  logic             bus_req_mine,
    output logic             req_nack,
    input  logic             bus_rsp_valid,
    input  logic [TAG_W-1:0] bus_rsp_tag,
    output logic             rsp_take,
    output logic             rsp_shared,
    output logic             rsp_known,
    output logic [1:0]       rsp_state,
    input  logic             snp_valid,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic [1:0]       snp_state,
    input  logic             cpu_valid,
    input  logic [BLK_W-1:0] cpu_blk,
    input  logic             cpu_write,
    output logic [1:0]       cpu_act,
    output logic [TAG_W-1:0] cpu_tag,
    output logic             table_full
);
    logic [DEPTH-1:0]      occ_v, hit_bus_v, hit_cpu_v;
    logic [DEPTH-1:0]      alloc_v, rel_v, grab_set_v, snp_v;
    logic [DEPTH-1:0]      orig_v, grab_v, known_v;
    logic [DEPTH-1:0][1:0] kind_v, cst_v;
    logic [TAG_W-1:0]      free_idx;
    logic                  any_free;
    act_t                  act;
    logic [1:0]            hit_kind;
    logic                  hit_any, hit_dying;

    assign req_nack = bus_req_valid && (|hit_bus_v);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign alloc_v[i]    = bus_req_valid && !req_nack && (bus_req_tag == TAG_W'(i));
        assign rel_v[i]      = bus_rsp_valid && (bus_rsp_tag == TAG_W'(i));
        assign snp_v[i]      = snp_valid && (snp_tag == TAG_W'(i));
        assign grab_set_v[i] = hit_cpu_v[i] && (act == ACT_GRAB);

        ort_slot #(.BLK_W(BLK_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc     (alloc_v[i]),
            .alloc_blk (bus_req_blk),
            .alloc_kind(bus_req_kind),
            .alloc_mine(bus_req_mine),
            .release_i (rel_v[i]),
            .grab_i    (grab_set_v[i]),
            .snp_i     (snp_v[i]),
            .snp_st    (snp_state),
            .bus_blk   (bus_req_blk),
            .cpu_blk   (cpu_blk),
            .occ       (occ_v[i]),
            .hit_bus   (hit_bus_v[i]),
            .hit_cpu   (hit_cpu_v[i]),
            .kind_o    (kind_v[i]),
            .orig_o    (orig_v[i]),
            .grab_o    (grab_v[i]),
            .known_o   (known_v[i]),
            .cst_o     (cst_v[i])
        );
    end

    ort_pick #(.DEPTH(DEPTH)) u_pick (
        .occ_v   (occ_v),
        .free_idx(free_idx),
        .any_free(any_free)
    );

    always_comb begin
        hit_kind = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_cpu_v[i]) hit_kind = hit_kind | kind_v[i];
        end
        hit_any   = |hit_cpu_v;
        hit_dying = |(hit_cpu_v & rel_v);
    end

    always_comb begin
        act = ACT_IDLE;
        if (cpu_valid) begin
            if (hit_any) begin
                if (!hit_dying && !cpu_write && hit_kind == RQ_READ) act = ACT_GRAB;
                else                                                 act = ACT_WAIT;
            end else if (any_free) begin
                act = ACT_ISSUE;
            end else begin
                act = ACT_WAIT;
            end
        end
    end

    always_comb begin
        cpu_act    = act;
        cpu_tag    = free_idx;
        table_full = !any_free;
        rsp_take   = bus_rsp_valid && occ_v[bus_rsp_tag] &&
                     (orig_v[bus_rsp_tag] || grab_v[bus_rsp_tag]);
        rsp_shared = bus_rsp_valid && occ_v[bus_rsp_tag] &&
                     grab_v[bus_rsp_tag] && !orig_v[bus_rsp_tag];
        rsp_known  = bus_rsp_valid && known_v[bus_rsp_tag];
        rsp_state  = bus_rsp_valid ? cst_v[bus_rsp_tag] : 2'd0;
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_cpu_v)); // R3
    AST_GRAB_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_act == ACT_GRAB) |-> (hit_any && !cpu_write)); // R5
    AST_ISSUE_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_act == ACT_ISSUE) |-> !occ_v[cpu_tag]); // R8
    AST_SHARED_IS_TAKER: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_shared |-> rsp_take); // R11
    AST_NACK_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        req_nack |-> (alloc_v == '0)); // R3
endmodule

// File: tb/split_req_table_bench.sv
module split_req_table_bench;
    localparam int DEPTH = 8;
    localparam int BLK_W = 26;
    localparam int TAG_W = 3;
    localparam logic [11:0] M_NACK = 12'h800, M_ACT = 12'h600, M_CT = 12'h1C0;
    localparam logic [11:0] M_RSP  = 12'h03E, M_FULL = 12'h001;
    localparam logic [1:0]  A_IDLE = 2'd0, A_ISSUE = 2'd1, A_GRAB = 2'd2, A_WAIT = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic             bus_req_valid, bus_req_mine, bus_rsp_valid, snp_valid, cpu_valid, cpu_write;
    logic [TAG_W-1:0] bus_req_tag, bus_rsp_tag, snp_tag;
    logic [BLK_W-1:0] bus_req_blk, cpu_blk;
    logic [1:0]       bus_req_kind, snp_state;
    logic             req_nack, rsp_take, rsp_shared, rsp_known, table_full;
    logic [1:0]       rsp_state, cpu_act;
    logic [TAG_W-1:0] cpu_tag;

    typedef struct {
        string       rq;
        logic [11:0] e;
        logic [11:0] m;
    } exp_t;
    exp_t sb[$];
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    split_req_table #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_split_req_table (
        .clk(clk), .rst_n(rst_n),
        .bus_req_valid(bus_req_valid), .bus_req_tag(bus_req_tag), .bus_req_blk(bus_req_blk),
        .bus_req_kind(bus_req_kind), .bus_req_mine(bus_req_mine), .req_nack(req_nack),
        .bus_rsp_valid(bus_rsp_valid), .bus_rsp_tag(bus_rsp_tag),
        .rsp_take(rsp_take), .rsp_shared(rsp_shared), .rsp_known(rsp_known), .rsp_state(rsp_state),
        .snp_valid(snp_valid), .snp_tag(snp_tag), .snp_state(snp_state),
        .cpu_valid(cpu_valid), .cpu_blk(cpu_blk), .cpu_write(cpu_write),
        .cpu_act(cpu_act), .cpu_tag(cpu_tag), .table_full(table_full)
    );

    function automatic logic [11:0] ex(logic nk, logic [1:0] ac, logic [2:0] ct, logic tk,
                                       logic sh, logic kn, logic [1:0] st, logic fu);
        return {nk, ac, ct, tk, sh, kn, st, fu};
    endfunction

    // Monitor: compare mid-cycle, away from the rising edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t it;
            logic [11:0] obs;
            it  = sb.pop_front();
            obs = {req_nack, cpu_act, cpu_tag, rsp_take, rsp_shared, rsp_known, rsp_state, table_full};
            n_run++;
            if (((obs ^ it.e) & it.m) != 0) begin
                n_fail++;
                $display("FAIL %s: actual %03h expected %03h (mask %03h)", it.rq, obs & it.m, it.e & it.m, it.m);
            end
        end
    end

    task automatic idle_in();
        bus_req_valid = 0; bus_req_tag = '0; bus_req_blk = '0; bus_req_kind = 0; bus_req_mine = 0;
        bus_rsp_valid = 0; bus_rsp_tag = '0; snp_valid = 0; snp_tag = '0; snp_state = 0;
        cpu_valid = 0; cpu_blk = '0; cpu_write = 0;
    endtask

    task automatic step();
        @(posedge clk); #1; idle_in();
    endtask

    task automatic go(string rq, logic [11:0] e, logic [11:0] m);
        sb.push_back('{rq, e, m});
        step();
    endtask

    task automatic breq(int t, int b, int k, bit mine);
        bus_req_valid = 1; bus_req_tag = TAG_W'(t); bus_req_blk = BLK_W'(b);
        bus_req_kind = 2'(k); bus_req_mine = mine;
    endtask

    task automatic rsp(int t);
        bus_rsp_valid = 1; bus_rsp_tag = TAG_W'(t);
    endtask

    task automatic look(int b, bit wr);
        cpu_valid = 1; cpu_blk = BLK_W'(b); cpu_write = wr;
    endtask

    initial begin
        idle_in();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        look('hA0, 0); go("R1 reset lookup", ex(0, A_ISSUE, 0, 0, 0, 0, 0, 0), 12'hFFF);
        // R2 foreign read recorded at tag 0
        breq(0, 'hA0, 0, 0); go("R2 no nack", ex(0, 0, 0, 0, 0, 0, 0, 0), M_NACK);
        look('hA0, 0); go("R5 grab pending read", ex(0, A_GRAB, 0, 0, 0, 0, 0, 0), M_ACT);
        // R3 conflicting request, R8 lowest free tag
        breq(1, 'hA0, 1, 1); look('hB0, 1);
        go("R3 nack + R8 issue tag1", ex(1, A_ISSUE, 1, 0, 0, 0, 0, 0), M_NACK | M_ACT | M_CT);
        look('hB0, 0); go("R3 nacked req left tag1 free", ex(0, A_ISSUE, 1, 0, 0, 0, 0, 0), M_ACT | M_CT);
        breq(1, 'hB0, 1, 1); go("R2 own readx", ex(0, 0, 0, 0, 0, 0, 0, 0), M_NACK);
        look('hB0, 0); go("R6 read vs readx", ex(0, A_WAIT, 0, 0, 0, 0, 0, 0), M_ACT);
        look('hA0, 1); go("R6 write vs read", ex(0, A_WAIT, 0, 0, 0, 0, 0, 0), M_ACT);
        snp_valid = 1; snp_tag = 1; snp_state = 2'd3; step();
        rsp(1); go("R4 R9 own response", ex(0, 0, 0, 1, 0, 1, 3, 0), M_RSP);
        rsp(0); go("R5 R11 grabbed response", ex(0, 0, 0, 1, 1, 0, 0, 0), M_RSP);
        look('hA0, 0); go("R7 released tag reusable", ex(0, A_ISSUE, 0, 0, 0, 0, 0, 0), M_ACT | M_CT);
        breq(2, 'hC0, 0, 0); step();
        rsp(2); go("R4 foreign not taken", ex(0, 0, 0, 0, 0, 0, 0, 0), M_RSP);
        breq(3, 'hD0, 0, 1); step();
        look('hD0, 0); go("R11 originator grabs", ex(0, A_GRAB, 0, 0, 0, 0, 0, 0), M_ACT);
        rsp(3); go("R11 originator no shared", ex(0, 0, 0, 1, 0, 0, 0, 0), M_RSP);
        breq(4, 'hE0, 0, 0); step();
        rsp(4); look('hE0, 0); go("R10 dying match waits", ex(0, A_WAIT, 0, 0, 0, 0, 0, 0), M_ACT);
        look('hE0, 0); go("R7 after release", ex(0, A_ISSUE, 0, 0, 0, 0, 0, 0), M_ACT | M_CT);
        for (int i = 0; i < DEPTH; i++) begin
            breq(i, 'h100 + i, 0, 0); step();
        end
        look('h200, 0); go("R8 full waits", ex(0, A_WAIT, 0, 0, 0, 0, 0, 1), M_ACT | M_FULL);
        breq(0, 'h103, 0, 0); go("R3 nack on full table", ex(1, 0, 0, 0, 0, 0, 0, 1), M_NACK | M_FULL);
        rsp(5); step();
        look('h200, 1); go("R8 freed tag5", ex(0, A_ISSUE, 5, 0, 0, 0, 0, 0), M_ACT | M_CT | M_FULL);
        repeat (2) @(posedge clk);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule